// File: doc/BRIEF.md
# Clock-Gated Five-Stage RISC Pipeline

This block is a 32-bit in-order integer core. Each instruction passes through fetch, decode, execute, memory and writeback. Instructions and data are kept in two separate synchronous word arrays inside the block. A load port fills both arrays while the core is held in reset. The core handles five register-register operations: add, subtract, and, or, and a multiply that keeps the low 32 bits. It also handles word load, word store, branch-if-equal and an absolute jump.

Each pipeline register has a valid bit. Its data fields are written only when the stage feeding it passes on real work. A bubble therefore clears the valid bit and leaves the wide fields untouched, which models clock gating as a register enable. Results are forwarded from the memory and writeback stages. Branches and jumps resolve in decode, so a taken redirect discards one fetched instruction. The retirement streams appear on two port groups: one for register writes and one for data-array stores.

Top module: `gated_pipe_core`

## Requirements
- R1: After reset is released, fetch starts at byte address 0. The first instruction's register write appears on the writeback port on the 4th rising edge after release. No write or store is reported while reset is held.
- R2: R-type instructions have opcode 0 in bits 31:26, rs in bits 25:21, rt in bits 20:16, rd in bits 15:11, shift amount 0 in bits 10:6, and the function code in bits 5:0. The function codes are 0x20 add, 0x22 subtract, 0x24 and, 0x25 or, and 0x18 multiply (low 32 bits). Each writes rd with rs op rt.
- R3: Load (opcode 0x23) and store (opcode 0x2B) use the address rs plus the sign-extended immediate in bits 15:0. The word index is address bits 9:2. A load writes the word into rt. A store writes rt and reports the byte address and data on the store port.
- R4: Register 0 reads as zero, and a write to it is dropped and not reported.
- R5: An instruction that reads a register written by one of the three preceding instructions gets the new value.
- R6: An instruction that uses the result of the load just before it is held for exactly one cycle. Its write retires two cycles after the load's write.
- R7: Branch-if-equal (opcode 0x04) redirects to PC+4 plus the sign-extended immediate times 4 when rs equals rt. The instruction fetched after a taken branch never executes. A branch that is not taken continues at PC+4.
- R8: Jump (opcode 0x02) redirects to {PC+4 bits 31:28, the 26-bit target field, 00}. The instruction fetched after it never executes.
- R9: A pipeline register's data fields hold their value in any cycle in which the stage feeding it delivers no valid instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_we | input | 1 | Write one word into an array through the load port |
| load_dmem | input | 1 | Selects the array for load_we: 0 instruction, 1 data |
| load_addr | input | LAW | Word index for the load port |
| load_data | input | 32 | Word to write through the load port |
| wb_valid_o | output | 1 | A register write retires this cycle |
| wb_rd_o | output | 5 | Destination register of the retiring write |
| wb_data_o | output | 32 | Value written |
| st_valid_o | output | 1 | A store updates the data array this cycle |
| st_addr_o | output | 32 | Byte address of the store |
| st_data_o | output | 32 | Word stored |

## Verification
Two programs run against an instruction-level interpreter. Both the write stream and the store stream are compared on every clock. The first program is a straight-line sequence with dependences at distances one, two and three, back-to-back loads with their consumers, a store followed by a reload of the same word, a negative store offset and a write to register 0. It separates missing or wrong forwarding from a missing or doubled load-use stall, and the stall is also timed. The second program uses a branch that is not taken, taken forward branches, a backward branch loop and a jump, each with a just-computed compare operand. It separates correct flushing from wrong-path execution and from stale operands at decode.

// File: rtl/gp_pkg.sv
package gp_pkg;
  localparam int XW = 32;

  localparam logic [5:0] OPC_REG  = 6'h00;
  localparam logic [5:0] OPC_LOAD = 6'h23;
  localparam logic [5:0] OPC_STOR = 6'h2B;
  localparam logic [5:0] OPC_BEQ  = 6'h04;
  localparam logic [5:0] OPC_JMP  = 6'h02;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_MUL = 6'h18;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_MUL
  } alu_op_e;

  typedef struct packed {
    logic          alu_like;
    logic          is_load;
    logic          is_store;
    logic          is_beq;
    logic          is_jump;
    logic          wr;
    logic          use_imm;
    logic          uses_rs;
    logic          uses_rt;
    alu_op_e       op;
    logic [4:0]    rs;
    logic [4:0]    rt;
    logic [4:0]    rd;
    logic [XW-1:0] imm;
    logic [25:0]   jidx;
  } dec_t;
endpackage

// File: rtl/gp_regfile.sv
module gp_regfile #(
  parameter int NREG = 32,
  parameter int W    = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic [AW-1:0] ra_i,
  input  logic [AW-1:0] rb_i,
  output logic [W-1:0]  ra_o,
  output logic [W-1:0]  rb_o,
  input  logic          we_i,
  input  logic [AW-1:0] wa_i,
  input  logic [W-1:0]  wd_i
);
  logic [W-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (we_i && wa_i != '0) regs[wa_i] <= wd_i;
  end

  assign ra_o = (ra_i == '0) ? '0 : regs[ra_i];
  assign rb_o = (rb_i == '0) ? '0 : regs[rb_i];
endmodule

// File: rtl/gp_alu.sv
module gp_alu
  import gp_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_op_e      op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] y_o
);
  always_comb begin
    case (op_i)
      ALU_ADD: y_o = a_i + b_i;
      ALU_SUB: y_o = a_i - b_i;
      ALU_AND: y_o = a_i & b_i;
      ALU_OR:  y_o = a_i | b_i;
      ALU_MUL: y_o = a_i * b_i;
      default: y_o = '0;
    endcase
  end
endmodule

// File: rtl/gp_decode.sv
module gp_decode
  import gp_pkg::*;
(
  input  logic [XW-1:0] instr_i,
  output dec_t          dec_o
);
  logic [5:0] opc;
  logic [5:0] fn;
  logic [4:0] shamt;

  assign opc   = instr_i[31:26];
  assign fn    = instr_i[5:0];
  assign shamt = instr_i[10:6];

  always_comb begin
    dec_o      = '0;
    dec_o.op   = ALU_ADD;
    dec_o.rs   = instr_i[25:21];
    dec_o.rt   = instr_i[20:16];
    dec_o.imm  = {{16{instr_i[15]}}, instr_i[15:0]};
    dec_o.jidx = instr_i[25:0];
    case (opc)
      OPC_REG: begin
        if (shamt == 5'd0) begin
          dec_o.alu_like = 1'b1;
          dec_o.uses_rs  = 1'b1;
          dec_o.uses_rt  = 1'b1;
          dec_o.rd       = instr_i[15:11];
          case (fn)
            FN_ADD:  dec_o.op = ALU_ADD;
            FN_SUB:  dec_o.op = ALU_SUB;
            FN_AND:  dec_o.op = ALU_AND;
            FN_OR:   dec_o.op = ALU_OR;
            FN_MUL:  dec_o.op = ALU_MUL;
            default: dec_o.alu_like = 1'b0;
          endcase
        end
      end
      OPC_LOAD: begin
        dec_o.is_load = 1'b1;
        dec_o.uses_rs = 1'b1;
        dec_o.use_imm = 1'b1;
        dec_o.rd      = instr_i[20:16];
      end
      OPC_STOR: begin
        dec_o.is_store = 1'b1;
        dec_o.uses_rs  = 1'b1;
        dec_o.uses_rt  = 1'b1;
        dec_o.use_imm  = 1'b1;
      end
      OPC_BEQ: begin
        dec_o.is_beq  = 1'b1;
        dec_o.uses_rs = 1'b1;
        dec_o.uses_rt = 1'b1;
      end
      OPC_JMP: dec_o.is_jump = 1'b1;
      default: ;
    endcase
    dec_o.wr = (dec_o.alu_like || dec_o.is_load) && (dec_o.rd != 5'd0);
  end
endmodule

// File: rtl/gated_pipe_core.sv
module gated_pipe_core
  import gp_pkg::*;
#(
  parameter int IMEM_WORDS = 256,
  parameter int DMEM_WORDS = 256,
  localparam int IAW = $clog2(IMEM_WORDS),
  localparam int DAW = $clog2(DMEM_WORDS),
  localparam int LAW = (IAW > DAW) ? IAW : DAW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load_we,
  input  logic           load_dmem,
  input  logic [LAW-1:0] load_addr,
  input  logic [XW-1:0]  load_data,
  output logic           wb_valid_o,
  output logic [4:0]     wb_rd_o,
  output logic [XW-1:0]  wb_data_o,
  output logic           st_valid_o,
  output logic [XW-1:0]  st_addr_o,
  output logic [XW-1:0]  st_data_o
);
  // fetch / IF-ID
  logic [XW-1:0] pc, id_pc, id_instr;
  logic          id_valid;
  // hazard / redirect
  logic          stall, redirect, br_taken, id_go;
  logic          ex_hits, mem_ld_hits;
  logic [XW-1:0] id_pc4, redirect_pc;
  // decode
  dec_t          d;
  logic [XW-1:0] rf_a, rf_b, id_a, id_b;
  // ID-EX
  logic          ex_valid, ex_wr, ex_load, ex_store, ex_use_imm;
  alu_op_e       ex_op;
  logic [4:0]    ex_rs, ex_rt, ex_rd;
  logic [XW-1:0] ex_a, ex_b, ex_imm, ex_fa, ex_fb, alu_b, ex_y;
  // EX-MEM
  logic          mem_valid, mem_wr, mem_load, mem_store, mem_fwd_ok;
  logic [4:0]    mem_rd;
  logic [XW-1:0] mem_alu, mem_sd;
  // MEM-WB
  logic          wb_valid, wb_wr, wb_load, wb_we;
  logic [4:0]    wb_rd;
  logic [XW-1:0] wb_alu, dm_rdata, wb_result;

  logic [XW-1:0] imem [IMEM_WORDS];
  logic [XW-1:0] dmem [DMEM_WORDS];

  // ---------------- fetch ----------------
  always_ff @(posedge clk) begin
    if (load_we && !load_dmem) imem[load_addr[IAW-1:0]] <= load_data;
  end

  always_ff @(posedge clk) begin
    if (rst)         id_instr <= '0;
    else if (!stall) id_instr <= imem[pc[IAW+1:2]];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc       <= '0;
      id_pc    <= '0;
      id_valid <= 1'b0;
    end else if (!stall) begin
      id_pc    <= pc;
      id_valid <= !redirect;
      pc       <= redirect ? redirect_pc : pc + 32'd4;
    end
  end

  // ---------------- decode ----------------
  gp_decode u_dec (.instr_i(id_instr), .dec_o(d));

  gp_regfile #(.NREG(32), .W(XW)) u_rf (
    .clk(clk), .ra_i(d.rs), .rb_i(d.rt), .ra_o(rf_a), .rb_o(rf_b),
    .we_i(wb_we), .wa_i(wb_rd), .wd_i(wb_result)
  );

  assign mem_fwd_ok = mem_valid && mem_wr && !mem_load;
  assign wb_we      = wb_valid && wb_wr;
  assign wb_result  = wb_load ? dm_rdata : wb_alu;

  always_comb begin
    id_a = rf_a;
    if (mem_fwd_ok && mem_rd == d.rs)  id_a = mem_alu;
    else if (wb_we && wb_rd == d.rs)   id_a = wb_result;
    id_b = rf_b;
    if (mem_fwd_ok && mem_rd == d.rt)  id_b = mem_alu;
    else if (wb_we && wb_rd == d.rt)   id_b = wb_result;
  end

  assign ex_hits     = ex_valid && ex_wr &&
                       ((d.uses_rs && ex_rd == d.rs) || (d.uses_rt && ex_rd == d.rt));
  assign mem_ld_hits = mem_valid && mem_wr && mem_load &&
                       ((d.uses_rs && mem_rd == d.rs) || (d.uses_rt && mem_rd == d.rt));
  assign stall       = id_valid && ((ex_hits && (ex_load || d.is_beq)) ||
                                    (mem_ld_hits && d.is_beq));

  assign br_taken    = d.is_beq && (id_a == id_b);
  assign redirect    = id_valid && !stall && (d.is_jump || br_taken);
  assign id_pc4      = id_pc + 32'd4;
  assign redirect_pc = d.is_jump ? {id_pc4[31:28], d.jidx, 2'b00}
                                 : id_pc4 + (d.imm << 2);
  assign id_go       = id_valid && !stall && (d.alu_like || d.is_load || d.is_store);

  // ---------------- ID-EX (data gated by id_go) ----------------
  always_ff @(posedge clk) begin
    if (rst) ex_valid <= 1'b0;
    else     ex_valid <= id_go;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ex_op <= ALU_ADD; ex_a <= '0; ex_b <= '0; ex_imm <= '0;
      ex_rs <= '0; ex_rt <= '0; ex_rd <= '0;
      ex_wr <= 1'b0; ex_load <= 1'b0; ex_store <= 1'b0; ex_use_imm <= 1'b0;
    end else if (id_go) begin
      ex_op <= d.op; ex_a <= id_a; ex_b <= id_b; ex_imm <= d.imm;
      ex_rs <= d.rs; ex_rt <= d.rt; ex_rd <= d.rd;
      ex_wr <= d.wr; ex_load <= d.is_load; ex_store <= d.is_store;
      ex_use_imm <= d.use_imm;
    end
  end

  // ---------------- execute ----------------
  always_comb begin
    ex_fa = ex_a;
    if (mem_fwd_ok && mem_rd == ex_rs)  ex_fa = mem_alu;
    else if (wb_we && wb_rd == ex_rs)   ex_fa = wb_result;
    ex_fb = ex_b;
    if (mem_fwd_ok && mem_rd == ex_rt)  ex_fb = mem_alu;
    else if (wb_we && wb_rd == ex_rt)   ex_fb = wb_result;
  end

  assign alu_b = ex_use_imm ? ex_imm : ex_fb;

  gp_alu #(.W(XW)) u_alu (.op_i(ex_op), .a_i(ex_fa), .b_i(alu_b), .y_o(ex_y));

  // ---------------- EX-MEM (data gated by ex_valid) ----------------
  always_ff @(posedge clk) begin
    if (rst) mem_valid <= 1'b0;
    else     mem_valid <= ex_valid;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_alu <= '0; mem_sd <= '0; mem_rd <= '0;
      mem_wr <= 1'b0; mem_load <= 1'b0; mem_store <= 1'b0;
    end else if (ex_valid) begin
      mem_alu <= ex_y; mem_sd <= ex_fb; mem_rd <= ex_rd;
      mem_wr <= ex_wr; mem_load <= ex_load; mem_store <= ex_store;
    end
  end

  // ---------------- data array ----------------
  always_ff @(posedge clk) begin
    if (load_we && load_dmem)         dmem[load_addr[DAW-1:0]] <= load_data;
    else if (mem_valid && mem_store)  dmem[mem_alu[DAW+1:2]]   <= mem_sd;
  end

  always_ff @(posedge clk) begin
    if (rst)                         dm_rdata <= '0;
    else if (mem_valid && mem_load)  dm_rdata <= dmem[mem_alu[DAW+1:2]];
  end

  // ---------------- MEM-WB (data gated by mem_valid) ----------------
  always_ff @(posedge clk) begin
    if (rst) wb_valid <= 1'b0;
    else     wb_valid <= mem_valid;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wb_alu <= '0; wb_rd <= '0; wb_wr <= 1'b0; wb_load <= 1'b0;
    end else if (mem_valid) begin
      wb_alu <= mem_alu; wb_rd <= mem_rd; wb_wr <= mem_wr; wb_load <= mem_load;
    end
  end

  assign wb_valid_o = wb_we;
  assign wb_rd_o    = wb_rd;
  assign wb_data_o  = wb_result;
  assign st_valid_o = mem_valid && mem_store;
  assign st_addr_o  = mem_alu;
  assign st_data_o  = mem_sd;
endmodule

// File: rtl/gated_pipe_core_chk.sv
module gated_pipe_core_chk (
  input logic        clk,
  input logic        rst,
  input logic        stall,
  input logic        redirect,
  input logic        id_valid,
  input logic        id_go,
  input logic        ex_valid,
  input logic        mem_valid,
  input logic [31:0] pc,
  input logic [31:0] ex_a,
  input logic [31:0] mem_alu,
  input logic [31:0] wb_alu,
  input logic        wb_valid_o,
  input logic [4:0]  wb_rd_o
);
  // R9
  idex_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !id_go |=> $stable(ex_a));
  // R9
  exmem_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ex_valid |=> $stable(mem_alu));
  // R9
  memwb_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !mem_valid |=> $stable(wb_alu));
  // R6
  stall_bubble_chk: assert property (@(posedge clk) disable iff (rst)
    stall |=> (!ex_valid && $stable(pc)));
  // R7
  redirect_flush_chk: assert property (@(posedge clk) disable iff (rst)
    redirect |=> !id_valid);
  // R4
  no_r0_write_chk: assert property (@(posedge clk) disable iff (rst)
    wb_valid_o |-> (wb_rd_o != 5'd0));
  // R1
  wb_source_chk: assert property (@(posedge clk) disable iff (rst)
    wb_valid_o |-> $past(mem_valid));
endmodule

bind gated_pipe_core gated_pipe_core_chk u_chk (
  .clk(clk), .rst(rst), .stall(stall), .redirect(redirect),
  .id_valid(id_valid), .id_go(id_go), .ex_valid(ex_valid),
  .mem_valid(mem_valid), .pc(pc), .ex_a(ex_a), .mem_alu(mem_alu),
  .wb_alu(wb_alu), .wb_valid_o(wb_valid_o), .wb_rd_o(wb_rd_o)
);

// File: tb/gated_pipe_core_bench.sv
module gated_pipe_core_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        load_we = 1'b0, load_dmem = 1'b0;
  logic [7:0]  load_addr = '0;
  logic [31:0] load_data = '0;
  logic        wb_valid_o, st_valid_o;
  logic [4:0]  wb_rd_o;
  logic [31:0] wb_data_o, st_addr_o, st_data_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  gated_pipe_core u_gated_pipe_core (
    .clk(clk), .rst(rst), .load_we(load_we), .load_dmem(load_dmem),
    .load_addr(load_addr), .load_data(load_data),
    .wb_valid_o(wb_valid_o), .wb_rd_o(wb_rd_o), .wb_data_o(wb_data_o),
    .st_valid_o(st_valid_o), .st_addr_o(st_addr_o), .st_data_o(st_data_o)
  );

  int n_chk = 0, n_err = 0;
  bit done = 0;

  typedef struct packed { logic [4:0] rd; logic [31:0] v; } wbe_t;
  typedef struct packed { logic [31:0] a; logic [31:0] v; } ste_t;
  wbe_t wb_q[$];
  ste_t st_q[$];

  logic [31:0] prog [32];
  logic [31:0] mr [32];
  logic [31:0] md [256];
  logic [31:0] last_wb [32];
  bit          written [32];
  int          wb_cyc [32];
  int          first_wb;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] e_r(input logic [5:0] fn, input logic [4:0] rd, input logic [4:0] rs, input logic [4:0] rt);
    return {6'h00, rs, rt, rd, 5'd0, fn};
  endfunction
  function automatic logic [31:0] e_i(input logic [5:0] opc, input logic [4:0] rt, input logic [4:0] rs, input int off);
    logic [15:0] o = off[15:0];
    return {opc, rs, rt, o};
  endfunction
  function automatic logic [31:0] e_j(input int idx);
    logic [25:0] t = idx[25:0];
    return {6'h02, t};
  endfunction

  // behavioural instruction interpreter
  task automatic model_run();
    int pc = 0;
    for (int step = 0; step < 500; step++) begin
      logic [31:0] ins = prog[pc];
      logic [4:0]  s = ins[25:21], t = ins[20:16], d = ins[15:11];
      logic [31:0] imm = {{16{ins[15]}}, ins[15:0]};
      logic [31:0] v, addr;
      int nxt = pc + 1;
      case (ins[31:26])
        6'h00: begin
          case (ins[5:0])
            6'h20: v = mr[s] + mr[t];
            6'h22: v = mr[s] - mr[t];
            6'h24: v = mr[s] & mr[t];
            6'h25: v = mr[s] | mr[t];
            6'h18: v = mr[s] * mr[t];
            default: v = 32'd0;
          endcase
          if (d != 0) begin mr[d] = v; wb_q.push_back({d, v}); end
        end
        6'h23: begin
          addr = mr[s] + imm; v = md[addr[9:2]];
          if (t != 0) begin mr[t] = v; wb_q.push_back({t, v}); end
        end
        6'h2B: begin
          addr = mr[s] + imm; md[addr[9:2]] = mr[t];
          st_q.push_back({addr, mr[t]});
        end
        6'h04: if (mr[s] == mr[t]) nxt = pc + 1 + $signed(imm);
        6'h02: nxt = int'(ins[25:0]);
        default: ;
      endcase
      if (nxt == pc) break;
      pc = nxt;
    end
  endtask

  task automatic load_all();
    for (int i = 0; i < 32; i++) begin
      @(negedge clk); load_we = 1; load_dmem = 0; load_addr = 8'(i); load_data = prog[i];
    end
    @(negedge clk); load_we = 0;
  endtask

  task automatic load_data_word(input int idx, input logic [31:0] v);
    @(negedge clk); load_we = 1; load_dmem = 1; load_addr = 8'(idx); load_data = v;
    md[idx] = v;
    @(negedge clk); load_we = 0;
  endtask

  task automatic run_prog(input int ncyc);
    for (int i = 0; i < 32; i++) begin written[i] = 0; wb_cyc[i] = -1; last_wb[i] = '0; end
    first_wb = -1;
    @(negedge clk); rst = 1;
    load_all();
    model_run();
    @(negedge clk);
    chk(!wb_valid_o && !st_valid_o, "R1 quiet in reset", {30'd0, wb_valid_o, st_valid_o}, 32'd0);
    rst = 0;
    for (int cyc = 1; cyc <= ncyc; cyc++) begin
      @(negedge clk);
      if (wb_valid_o) begin
        chk(wb_rd_o != 5'd0, "R4 no r0 report", {27'd0, wb_rd_o}, 32'd1);
        if (first_wb < 0) first_wb = cyc;
        written[wb_rd_o] = 1; last_wb[wb_rd_o] = wb_data_o; wb_cyc[wb_rd_o] = cyc;
        if (wb_q.size() == 0) chk(0, "R2 R3 R5 unexpected write", {27'd0, wb_rd_o}, 32'd0);
        else begin
          wbe_t e = wb_q.pop_front();
          chk(wb_rd_o == e.rd, "R2 R3 R5 write reg", {27'd0, wb_rd_o}, {27'd0, e.rd});
          chk(wb_data_o == e.v, "R2 R3 R5 write data", wb_data_o, e.v);
        end
      end
      if (st_valid_o) begin
        if (st_q.size() == 0) chk(0, "R3 unexpected store", st_addr_o, 32'd0);
        else begin
          ste_t e = st_q.pop_front();
          chk(st_addr_o == e.a, "R3 store address", st_addr_o, e.a);
          chk(st_data_o == e.v, "R3 store data", st_data_o, e.v);
        end
      end
    end
    chk(wb_q.size() == 0, "R7 R8 missing writes", 32'(wb_q.size()), 32'd0);
    chk(st_q.size() == 0, "R3 missing stores", 32'(st_q.size()), 32'd0);
    wb_q.delete(); st_q.delete();
  endtask

  initial begin
    for (int i = 0; i < 32; i++) mr[i] = '0;
    repeat (3) @(negedge clk);
    load_data_word(0, 32'd5);
    load_data_word(1, 32'd7);
    load_data_word(2, 32'hFFFF_FFF0);
    load_data_word(3, 32'h1234_5678);

    // program A: arithmetic, forwarding, load-use, stores
    for (int i = 0; i < 32; i++) prog[i] = '0;
    prog[0]  = e_i(6'h23, 1, 0, 0);
    prog[1]  = e_i(6'h23, 2, 0, 4);
    prog[2]  = e_i(6'h23, 3, 0, 8);
    prog[3]  = e_i(6'h23, 4, 0, 12);
    prog[4]  = e_r(6'h24, 7, 4, 3);
    prog[5]  = e_r(6'h20, 5, 1, 2);
    prog[6]  = e_r(6'h22, 6, 5, 1);
    prog[7]  = e_r(6'h25, 8, 7, 6);
    prog[8]  = e_r(6'h18, 9, 6, 3);
    prog[9]  = e_r(6'h20, 0, 1, 2);
    prog[10] = e_r(6'h20, 10, 0, 1);
    prog[11] = e_i(6'h2B, 9, 0, 16);
    prog[12] = e_i(6'h2B, 6, 5, -4);
    prog[13] = e_i(6'h23, 11, 0, 16);
    prog[14] = e_r(6'h20, 12, 11, 11);
    prog[15] = e_i(6'h23, 13, 0, 8);
    prog[16] = e_r(6'h22, 14, 13, 9);
    prog[17] = e_j(17);
    run_prog(100);
    chk(first_wb == 4, "R1 first write edge", 32'(first_wb), 32'd4);
    chk(last_wb[7] == 32'h1234_5670, "R2 and", last_wb[7], 32'h1234_5670);
    chk(last_wb[9] == 32'hFFFF_FF90, "R2 mul", last_wb[9], 32'hFFFF_FF90);
    chk(last_wb[6] == 32'd7, "R5 distance one", last_wb[6], 32'd7);
    chk(last_wb[8] == 32'h1234_5677, "R5 mixed distances", last_wb[8], 32'h1234_5677);
    chk(last_wb[10] == 32'd5, "R4 r0 reads zero", last_wb[10], 32'd5);
    chk(last_wb[11] == 32'hFFFF_FF90, "R3 store then load", last_wb[11], 32'hFFFF_FF90);
    chk(last_wb[14] == 32'd119, "R3 negative offset store", last_wb[14], 32'd119);
    chk(wb_cyc[7] - wb_cyc[4] == 2, "R6 load-use gap", 32'(wb_cyc[7] - wb_cyc[4]), 32'd2);
    chk(wb_cyc[12] - wb_cyc[11] == 2, "R6 load-use gap 2", 32'(wb_cyc[12] - wb_cyc[11]), 32'd2);
    chk(wb_cyc[5] - wb_cyc[7] == 1, "R6 no extra stall", 32'(wb_cyc[5] - wb_cyc[7]), 32'd1);

    // program B: branches and jumps
    for (int i = 0; i < 32; i++) prog[i] = '0;
    prog[0]  = e_i(6'h23, 1, 0, 0);
    prog[1]  = e_i(6'h23, 2, 0, 4);
    prog[2]  = e_i(6'h04, 2, 1, 1);
    prog[3]  = e_r(6'h20, 3, 1, 1);
    prog[4]  = e_i(6'h04, 3, 3, 1);
    prog[5]  = e_r(6'h20, 4, 2, 2);
    prog[6]  = e_r(6'h20, 5, 3, 2);
    prog[7]  = e_j(9);
    prog[8]  = e_r(6'h20, 6, 1, 1);
    prog[9]  = e_r(6'h22, 7, 2, 1);
    prog[10] = e_r(6'h20, 15, 1, 3);
    prog[11] = e_r(6'h20, 10, 0, 0);
    prog[12] = e_r(6'h20, 10, 10, 1);
    prog[13] = e_i(6'h04, 15, 10, 1);
    prog[14] = e_i(6'h04, 0, 0, -3);
    prog[15] = e_r(6'h25, 11, 10, 2);
    prog[16] = e_j(16);
    run_prog(150);
    chk(written[3] && last_wb[3] == 32'd10, "R7 not-taken falls through", last_wb[3], 32'd10);
    chk(!written[4], "R7 taken branch flushes", {31'd0, written[4]}, 32'd0);
    chk(last_wb[5] == 32'd17, "R7 branch target", last_wb[5], 32'd17);
    chk(!written[6], "R8 jump flushes", {31'd0, written[6]}, 32'd0);
    chk(last_wb[7] == 32'd2, "R8 jump target", last_wb[7], 32'd2);
    chk(last_wb[11] == 32'd15, "R7 backward loop exit", last_wb[11], 32'd15);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    for (int t = 0; t < WATCHDOG; t++) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired actual=%0d expected=done", WATCHDOG);
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end
endmodule